// File: doc/BRIEF.md
# Clock-Paced Linked-List Cell Scheduler

This block decides when constant-bit-rate cells leave a switch controller. Every output (eight by default) owns two chains of virtual circuits, one for the top priority level (3) and one for the level below it (2). Each chain is a linked list of slots. A slot names a VC and points to the next slot. A slow external rate clock for each priority paces the walk down every chain of that priority. Each high-to-low transition of the rate clock gives every chain of that priority permission to schedule one cell.

A scheduled cell leaves as a one-cycle request carrying output, priority and VC. The chain then waits until the fabric reports that cell serviced. Only then does the chain move to the next slot. A rate-clock high phase of eight or more system cycles is a frame marker. It sends the chain back to its first slot, but never before every slot of the current pass has been handled. A VC with nothing queued is passed over, and that slot still counts toward the pass. The same VC may sit in several slots of one chain, which gives it a larger share of each frame. Slot contents, chain heads and chain lengths are loaded through a configuration port.

Top module: `cbr_sched`

## Requirements
- R1: After reset no request is raised. It stays low until a chain with non-zero length is configured and its rate clock falls.
- R2: Each falling edge of `rate_clk[1]` (priority 3) or `rate_clk[0]` (priority 2), after a two-flop synchroniser, grants each chain of that priority one schedule credit. Credits do not accumulate beyond one. With high phases of eight cycles or more, exactly one cell is requested per falling edge.
- R3: A slot write (`cfg_list_sel`=0) stores the VC in `cfg_data[3:0]` and the next slot in `cfg_data[8:4]`. A chain requests the VC of its current slot and, after each serviced cell, follows the next pointer.
- R4: After a chain has issued a request, it issues no further request until `svc_valid` arrives with that chain's output and priority. A credit granted while it waits is kept.
- R5: Once every slot of a pass has been handled, the chain issues nothing on short rate-clock pulses. A high phase of 8 or more cycles returns it to its head slot, and the head cell is requested on that same edge.
- R6: A frame marker that arrives during a pass is remembered. The chain returns to its head as soon as the pass completes, not before.
- R7: A VC linked into several slots of one chain is requested once per slot in each pass.
- R8: A slot whose VC has its `vc_has_cell` bit low is skipped without a request and counts toward the pass. No request ever names a VC without a queued cell.
- R9: Chain address = output*2 + (priority 3 ? 0 : 1). When several chains are ready, the lowest chain address wins, so priority 3 precedes priority 2 on the same output. `req_pri`=1 means priority 3.
- R10: A chain of length zero never requests.
- R11: A chain write (`cfg_list_sel`=1) loads the head slot from `cfg_data[4:0]` and the length from `cfg_data[10:5]`. It restarts that chain at its head, clearing its credit, pending frame marker and waiting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_clk | input | 2 | Rate clocks: bit 1 paces priority 3, bit 0 paces priority 2 |
| vc_has_cell | input | 16 | One bit per VC: a cell is queued |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_list_sel | input | 1 | 0 = slot write, 1 = chain write |
| cfg_addr | input | 5 | Slot number or chain address |
| cfg_data | input | 11 | Write data, fields as in R3 and R11 |
| svc_valid | input | 1 | Fabric reports a cell serviced |
| svc_out | input | 3 | Output of the serviced cell |
| svc_pri | input | 1 | Priority of the serviced cell (1 = priority 3) |
| req_valid | output | 1 | Schedule request, one cycle per cell |
| req_out | output | 3 | Output of the request |
| req_pri | output | 1 | Priority of the request (1 = priority 3) |
| req_vc | output | 4 | VC of the request |

## Verification
The bound checker watches four rules on every cycle. No request names an empty VC. No chain requests again before its last cell is serviced. A zero-length chain stays silent. Every request is backed by a rate-clock fall that no earlier request of that chain has used. The walk order, the skipping of empty slots, weighted sublists, the delayed wrap after a mid-pass frame marker, the idle state after a completed pass and the ordering of the two priorities can only be shown by the bench, which compares request sequences against chains it builds itself.

// File: rtl/cbr_sched.sv
module cbr_sched #(
  parameter int N_OUT    = 8,
  parameter int N_VC     = 16,
  parameter int N_SLOT   = 32,
  parameter int MAX_LEN  = 32,
  parameter int FRAME_HI = 8,
  localparam int OW  = $clog2(N_OUT),
  localparam int VW  = $clog2(N_VC),
  localparam int SW  = $clog2(N_SLOT),
  localparam int LW  = $clog2(MAX_LEN + 1),
  localparam int LIW = OW + 1,
  localparam int AW  = (SW > LIW) ? SW : LIW,
  localparam int CW  = ((SW + VW) > (SW + LW)) ? (SW + VW) : (SW + LW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      rate_clk,
  input  logic [N_VC-1:0] vc_has_cell,
  input  logic            cfg_we,
  input  logic            cfg_list_sel,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [CW-1:0]   cfg_data,
  input  logic            svc_valid,
  input  logic [OW-1:0]   svc_out,
  input  logic            svc_pri,
  output logic            req_valid,
  output logic [OW-1:0]   req_out,
  output logic            req_pri,
  output logic [VW-1:0]   req_vc
);
  localparam int NL = 2 * N_OUT;
  localparam int HW = $clog2(FRAME_HI + 1);

  logic [1:0]    sy1, sy2, sy3, fall, mark;
  logic [HW-1:0] hcnt [2];
  logic [VW-1:0] slot_vc [N_SLOT];
  logic [SW-1:0] slot_nx [N_SLOT];
  logic [SW-1:0] head [NL];
  logic [SW-1:0] cur  [NL];
  logic [LW-1:0] len  [NL];
  logic [LW-1:0] pos  [NL];
  logic [NL-1:0] busy, credit, wpend, ready, skip, done;
  logic [LIW-1:0] sel, svc_l;

  assign fall    = sy3 & ~sy2;
  assign mark[0] = fall[0] && (hcnt[0] >= HW'(FRAME_HI));
  assign mark[1] = fall[1] && (hcnt[1] >= HW'(FRAME_HI));
  assign svc_l   = {svc_out, ~svc_pri};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= '0; sy2 <= '0; sy3 <= '0;
      hcnt[0] <= '0; hcnt[1] <= '0;
    end else begin
      sy1 <= rate_clk; sy2 <= sy1; sy3 <= sy2;
      for (int p = 0; p < 2; p++) begin
        if (!sy2[p])                      hcnt[p] <= '0;
        else if (hcnt[p] != HW'(FRAME_HI)) hcnt[p] <= hcnt[p] + 1'b1;
      end
    end
  end

  always_comb begin
    for (int l = 0; l < NL; l++) begin
      ready[l] = (pos[l] < len[l]) && !busy[l] && credit[l] && vc_has_cell[slot_vc[cur[l]]];
      skip[l]  = (pos[l] < len[l]) && !busy[l] && !vc_has_cell[slot_vc[cur[l]]];
      done[l]  = (len[l] != '0) && (pos[l] == len[l]);
    end
  end

  always_comb begin
    req_valid = 1'b0;
    sel       = '0;
    for (int l = NL - 1; l >= 0; l--)
      if (ready[l]) begin
        req_valid = 1'b1;
        sel       = LIW'(l);
      end
  end

  assign req_out = sel[LIW-1:1];
  assign req_pri = ~sel[0];
  assign req_vc  = slot_vc[cur[sel]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < N_SLOT; s++) begin
        slot_vc[s] <= '0;
        slot_nx[s] <= '0;
      end
    end else if (cfg_we && !cfg_list_sel) begin
      slot_vc[cfg_addr[SW-1:0]] <= cfg_data[VW-1:0];
      slot_nx[cfg_addr[SW-1:0]] <= cfg_data[VW+SW-1:VW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < NL; l++) begin
        head[l] <= '0; cur[l] <= '0; len[l] <= '0; pos[l] <= '0;
      end
      busy <= '0; credit <= '0; wpend <= '0;
    end else begin
      for (int l = 0; l < NL; l++) begin
        if (cfg_we && cfg_list_sel && cfg_addr[LIW-1:0] == LIW'(l)) begin
          head[l]   <= cfg_data[SW-1:0];
          cur[l]    <= cfg_data[SW-1:0];
          len[l]    <= cfg_data[SW+LW-1:SW];
          pos[l]    <= '0;
          busy[l]   <= 1'b0;
          credit[l] <= 1'b0;
          wpend[l]  <= 1'b0;
        end else begin
          if (req_valid && sel == LIW'(l)) credit[l] <= 1'b0;
          if (fall[(l % 2 == 0) ? 1 : 0])  credit[l] <= 1'b1;
          if (mark[(l % 2 == 0) ? 1 : 0] && len[l] != '0) wpend[l] <= 1'b1;
          if (req_valid && sel == LIW'(l)) begin
            busy[l] <= 1'b1;
          end else if (busy[l] && svc_valid && svc_l == LIW'(l)) begin
            busy[l] <= 1'b0;
            cur[l]  <= slot_nx[cur[l]];
            pos[l]  <= pos[l] + 1'b1;
          end else if (skip[l]) begin
            cur[l]  <= slot_nx[cur[l]];
            pos[l]  <= pos[l] + 1'b1;
          end else if (done[l] && (wpend[l] || mark[(l % 2 == 0) ? 1 : 0])) begin
            cur[l]   <= head[l];
            pos[l]   <= '0;
            wpend[l] <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/cbr_sched_chk.sv
module cbr_sched_chk #(
  parameter int N_OUT   = 8,
  parameter int N_VC    = 16,
  parameter int N_SLOT  = 32,
  parameter int MAX_LEN = 32,
  localparam int OW  = $clog2(N_OUT),
  localparam int VW  = $clog2(N_VC),
  localparam int SW  = $clog2(N_SLOT),
  localparam int LW  = $clog2(MAX_LEN + 1),
  localparam int LIW = OW + 1,
  localparam int AW  = (SW > LIW) ? SW : LIW,
  localparam int CW  = ((SW + VW) > (SW + LW)) ? (SW + VW) : (SW + LW)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      rate_clk,
  input logic [N_VC-1:0] vc_has_cell,
  input logic            cfg_we,
  input logic            cfg_list_sel,
  input logic [AW-1:0]   cfg_addr,
  input logic [CW-1:0]   cfg_data,
  input logic            svc_valid,
  input logic [OW-1:0]   svc_out,
  input logic            svc_pri,
  input logic            req_valid,
  input logic [OW-1:0]   req_out,
  input logic            req_pri,
  input logic [VW-1:0]   req_vc
);
  localparam int NL = 2 * N_OUT;

  logic [1:0]     c1, c2, c3, cfall;
  logic [NL-1:0]  outst, flag, nz;
  logic [LIW-1:0] rl, sl;

  assign cfall = c3 & ~c2;
  assign rl    = {req_out, ~req_pri};
  assign sl    = {svc_out, ~svc_pri};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1 <= '0; c2 <= '0; c3 <= '0;
      outst <= '0; flag <= '0; nz <= '0;
    end else begin
      c1 <= rate_clk; c2 <= c1; c3 <= c2;
      for (int l = 0; l < NL; l++) begin
        if (svc_valid && sl == LIW'(l)) outst[l] <= 1'b0;
        if (req_valid && rl == LIW'(l)) begin
          outst[l] <= 1'b1;
          flag[l]  <= 1'b0;
        end
        if (cfall[(l % 2 == 0) ? 1 : 0]) flag[l] <= 1'b1;
        if (cfg_we && cfg_list_sel && cfg_addr[LIW-1:0] == LIW'(l)) begin
          outst[l] <= 1'b0;
          flag[l]  <= 1'b0;
          nz[l]    <= |cfg_data[SW+LW-1:SW];
        end
      end
    end
  end

  assert_cell_present_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> vc_has_cell[req_vc]);
  assert_wait_serviced_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !outst[rl]);
  assert_empty_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> nz[rl]);
  assert_edge_paced_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> flag[rl]);
endmodule

bind cbr_sched cbr_sched_chk #(.N_OUT(N_OUT), .N_VC(N_VC), .N_SLOT(N_SLOT), .MAX_LEN(MAX_LEN)) u_chk (.*);

// File: tb/tb_cbr_sched.sv
module tb_cbr_sched;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  rate_clk = '0;
  logic [15:0] vc_has_cell = '1;
  logic        cfg_we = 1'b0;
  logic        cfg_list_sel = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [10:0] cfg_data = '0;
  logic        svc_valid = 1'b0;
  logic [2:0]  svc_out = '0;
  logic        svc_pri = 1'b0;
  logic        req_valid;
  logic [2:0]  req_out;
  logic        req_pri;
  logic [3:0]  req_vc;

  int n_chk = 0, n_bad = 0;
  int log_n = 0;
  int log_out [256];
  int log_pri [256];
  int log_vc  [256];
  int tmr  [16];
  bit hold [16];

  cbr_sched dut (.*);

  always #(CLK_P/2) clk = ~clk;

  function automatic int exp_vc(int k);
    return 3 + (k % 5);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_slot(int s, int vc, int nx);
    @(negedge clk);
    cfg_we = 1'b1; cfg_list_sel = 1'b0;
    cfg_addr = 5'(s); cfg_data = 11'((nx << 4) | vc);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_list(int o, int p3, int h, int n);
    @(negedge clk);
    cfg_we = 1'b1; cfg_list_sel = 1'b1;
    cfg_addr = 5'(o * 2 + (p3 != 0 ? 0 : 1)); cfg_data = 11'((n << 5) | h);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(logic [1:0] m, int hi, int lo);
    rate_clk = m;
    tick(hi);
    rate_clk = '0;
    tick(lo);
  endtask

  initial begin
    for (int l = 0; l < 16; l++) begin tmr[l] = 0; hold[l] = 1'b0; end
    forever begin
      bit fired;
      @(negedge clk);
      svc_valid = 1'b0;
      fired = 1'b0;
      for (int l = 0; l < 16; l++)
        if (!hold[l] && tmr[l] > 0) begin
          if (tmr[l] == 1) begin
            if (!fired) begin
              fired = 1'b1; svc_valid = 1'b1;
              svc_out = 3'(l / 2); svc_pri = (l % 2 == 0);
              tmr[l] = 0;
            end
          end else tmr[l]--;
        end
      if (req_valid) begin
        if (log_n < 256) begin
          log_out[log_n] = int'(req_out);
          log_pri[log_n] = int'(req_pri);
          log_vc[log_n]  = int'(req_vc);
        end
        log_n++;
        tmr[int'(req_out) * 2 + (req_pri ? 0 : 1)] = 2 + int'($urandom % 3);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    tick(3);
    rst_n = 1'b1;
    tick(4);
    check(req_valid == 1'b0, "R1 idle after reset", int'(req_valid), 0);
    pulse(2'b11, 3, 10);
    check(log_n == 0, "R1 no request before configuration", log_n, 0);

    for (int i = 0; i < 4; i++) cfg_slot(i, 4 + i, (i + 1) % 4);
    cfg_list(2, 1, 0, 4);
    log_n = 0;
    for (int i = 0; i < 4; i++) pulse(2'b10, 2, 12);
    check(log_n == 4, "R3 count of first pass", log_n, 4);
    for (int i = 0; i < 4; i++)
      check(log_vc[i] == 4 + i, "R3 chain order", log_vc[i], 4 + i);
    check(log_out[0] == 2 && log_pri[0] == 1, "R9 output and priority fields",
          log_out[0] * 2 + log_pri[0], 5);
    pulse(2'b10, 2, 12);
    pulse(2'b10, 2, 12);
    check(log_n == 4, "R5 idle after pass on short pulses", log_n, 4);
    pulse(2'b10, 10, 12);
    check(log_n == 5, "R5 frame marker restarts", log_n, 5);
    check(log_vc[4] == 4, "R5 restart at head", log_vc[4], 4);

    cfg_list(2, 1, 0, 4);
    log_n = 0;
    pulse(2'b10, 2, 14);
    pulse(2'b10, 10, 14);
    pulse(2'b10, 2, 14);
    check(log_n == 3, "R6 no early wrap", log_n, 3);
    check(log_vc[2] == 6, "R6 walk continues after marker", log_vc[2], 6);
    pulse(2'b10, 2, 14);
    pulse(2'b10, 2, 14);
    check(log_n == 5, "R6 wrap once pass completes", log_n, 5);
    check(log_vc[4] == 4, "R6 head after deferred wrap", log_vc[4], 4);

    vc_has_cell[5] = 1'b0;
    cfg_list(2, 1, 0, 4);
    log_n = 0;
    for (int i = 0; i < 4; i++) pulse(2'b10, 2, 14);
    check(log_n == 3, "R8 skipped slot ends pass", log_n, 3);
    check(log_vc[1] == 6, "R8 empty VC skipped", log_vc[1], 6);
    vc_has_cell[5] = 1'b1;

    cfg_list(2, 1, 0, 4);
    hold[4] = 1'b1;
    log_n = 0;
    for (int i = 0; i < 3; i++) pulse(2'b10, 2, 14);
    check(log_n == 1, "R4 held until serviced", log_n, 1);
    hold[4] = 1'b0;
    tick(12);
    check(log_n == 2, "R4 kept credit used after service", log_n, 2);
    check(log_vc[1] == 5, "R4 next slot after service", log_vc[1], 5);
    cfg_list(2, 1, 0, 0);
    tick(8);

    cfg_slot(4, 9, 5);
    cfg_slot(5, 10, 6);
    cfg_slot(6, 9, 4);
    cfg_list(5, 0, 4, 3);
    log_n = 0;
    for (int i = 0; i < 3; i++) pulse(2'b01, 2, 14);
    check(log_n == 3, "R7 sublist count", log_n, 3);
    check(log_vc[0] == 9 && log_vc[1] == 10 && log_vc[2] == 9, "R7 repeated VC",
          log_vc[0] * 100 + log_vc[1] * 10 + log_vc[2], 1009);
    check(log_out[0] == 5 && log_pri[0] == 0, "R9 priority-2 fields",
          log_out[0] * 2 + log_pri[0], 10);
    cfg_list(5, 0, 4, 0);

    cfg_slot(8, 1, 8);
    cfg_slot(9, 2, 9);
    cfg_list(1, 1, 8, 1);
    cfg_list(1, 0, 9, 1);
    log_n = 0;
    pulse(2'b11, 2, 16);
    check(log_n == 2, "R9 both priorities served", log_n, 2);
    check(log_pri[0] == 1 && log_vc[0] == 1, "R9 priority 3 first", log_vc[0], 1);
    check(log_pri[1] == 0 && log_vc[1] == 2, "R9 priority 2 second", log_vc[1], 2);
    cfg_list(1, 1, 8, 0);
    cfg_list(1, 0, 9, 0);

    cfg_list(0, 0, 0, 0);
    log_n = 0;
    pulse(2'b11, 10, 14);
    pulse(2'b01, 2, 14);
    check(log_n == 0, "R10 zero-length chains silent", log_n, 0);

    for (int i = 0; i < 5; i++) cfg_slot(10 + i, exp_vc(i), 10 + (i + 1) % 5);
    cfg_list(7, 1, 10, 5);
    log_n = 0;
    for (int i = 0; i < 40; i++)
      pulse(2'b10, 8 + int'($urandom % 13), 12 + int'($urandom % 9));
    check(log_n == 40, "R2 one cell per long pulse", log_n, 40);
    for (int k = 0; k < 40; k++) begin
      check(log_vc[k] == exp_vc(k), "R3 cyclic walk with markers", log_vc[k], exp_vc(k));
      check(log_out[k] == 7, "R11 chain address", log_out[k], 7);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule